// File: doc/BRIEF.md
# Interrupt File Indirect Register Access Decoder

This block sits between a core's indirect register access port and the storage of one interrupt file. Each request carries a select number, the requester's privilege level, a virtualization flag, a guest index, a register width flag (32 or 64 bits), new data and a write mask. The block checks whether the request is legal and works out the target page and register. It then performs a masked read-modify-write on that register and returns the value the register held before the write.

The file keeps, for each page, one bit of pending state and one bit of enable state per interrupt identity. It also keeps a one-bit delivery control and a threshold value. These are reached as groups of 32 or 64 bits, or as scalar registers. A parameter selects between a machine-level file, which has a single page, and a supervisor-level file, which has a host page plus guest pages.

Every request is answered exactly one cycle later. An illegal request returns zero, leaves all state untouched and raises an error flag. A legal request raises a one-cycle update strobe that carries the page, so that the downstream interrupt selection logic can re-evaluate that page.

Top module: `ifile_ireg_decoder`

## Requirements
- R1: A request presented with `req_valid` high in one cycle gives exactly one `rsp_valid` pulse in the next cycle. A cycle without a request gives no response.
- R2: In a supervisor-level file (`MACHINE_FILE`=0), only privilege 2'b01 is legal. A non-virtualized request targets page 0. A virtualized request targets page `req_guest`, which must be nonzero and below `NUM_PAGES`. Any other combination is illegal.
- R3: In a machine-level file (`MACHINE_FILE`=1), only privilege 2'b11 with `req_virt`=0 is legal, and it always targets page 0.
- R4: The select codes are laid out as follows:
  - 8'h00+n is pending group n, for n from 0 to 63.
  - 8'h40+n is enable group n, for n from 0 to 63.
  - 8'h80 is delivery control.
  - 8'h81 is the threshold.
  - 8'h82 is the top-interrupt register.
  - Every other code is illegal.
- R5: With `req_wide`=0, group n covers identities 32n to 32n+31. With `req_wide`=1, group n must be even, otherwise the request is illegal, and it covers identities 32n to 32n+63. Bit i of the data maps to the identity at the base of the group plus i.
- R6: A group whose word index (n in 32-bit mode, n/2 in 64-bit mode) is at or beyond `NUM_IDS` divided by the register width is illegal.
- R7: A legal access returns the register's old value. Each bit set in `req_wmask` takes the matching bit of `req_wdata`, and every other bit keeps its value.
- R8: Delivery control is writable only at bit 0. The threshold is writable only in its low `THR_W` bits. Bits above these read as zero.
- R9: Identity 0, which is bit 0 of pending group 0 and of enable group 0, always reads zero, and writes to it are ignored.
- R10: An illegal request returns zero data, sets `rsp_err` for one cycle, raises no update strobe and changes no state.
- R11: A legal request raises `upd_valid` for one cycle, together with the target page on `upd_page`.
- R12: A top-interrupt access is legal, reads zero, changes no pending, enable, delivery or threshold state, and raises the update strobe.
- R13: A write to one page leaves the registers of every other page unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request in this cycle |
| req_sel | input | 8 | Register select code |
| req_priv | input | 2 | Privilege of the requester (01 supervisor, 11 machine) |
| req_virt | input | 1 | Request comes from a virtualized context |
| req_guest | input | GUEST_W | Guest page index for virtualized requests |
| req_wide | input | 1 | 1: 64-bit register width, 0: 32-bit |
| req_wdata | input | 64 | New data |
| req_wmask | input | 64 | Bits to update |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Request was illegal |
| rsp_rdata | output | 64 | Old register value, zero on error |
| upd_valid | output | 1 | Page state may have changed, re-evaluate |
| upd_page | output | PAGE_W | Page to re-evaluate |

## Verification
Two cases are hard to reach from the ports. The first is a request whose legality hinges on several fields at once: a virtualized guest index that lies just past the page count, or an odd group number in 64-bit mode that would be legal in 32-bit mode. The bench reaches these by sweeping every select code in both widths, and every combination of privilege, virtualization flag and guest index. The second is a state change that leaks across a page or into the reserved identity 0. No single read shows it. The bench therefore fills every page with distinct patterns and then reads each group back. Because every access returns the old value, each later access in the sequence also checks what the earlier writes, including illegal and top-interrupt writes, left behind.

// File: rtl/ifile_pkg.sv
// Package: shared select codes, privilege codes and register kinds for the
// interrupt file access decoder.
package ifile_pkg;

    localparam logic [7:0] SEL_DLV = 8'h80;  // delivery control
    localparam logic [7:0] SEL_THR = 8'h81;  // threshold
    localparam logic [7:0] SEL_TOP = 8'h82;  // top-interrupt register

    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    typedef enum logic [2:0] {
        K_NONE,
        K_PEND,
        K_EN,
        K_DLV,
        K_THR,
        K_TOP
    } ireg_kind_e;

endpackage

// File: rtl/ifile_access_decode.sv
// Module: ifile_access_decode
// Purely combinational. It checks the legality of one indirect access and
// produces the target page, the register kind and the group word index.
// Assumes NUM_IDS is a power of two of at least 128 and GUEST_W >= PAGE_W.
module ifile_access_decode
    import ifile_pkg::*;
#(
    parameter int NUM_PAGES    = 4,
    parameter int NUM_IDS      = 128,
    parameter int GUEST_W      = 6,
    parameter bit MACHINE_FILE = 1'b0,
    parameter int PAGE_W       = 2
) (
    input  logic [7:0]         sel,
    input  logic [1:0]         priv,
    input  logic               virt,
    input  logic [GUEST_W-1:0] guest,
    input  logic               wide,
    output logic               legal,
    output ireg_kind_e         kind,
    output logic [PAGE_W-1:0]  page,
    output logic [5:0]         word
);

    localparam int WORDS_32 = NUM_IDS / 32;
    localparam int WORDS_64 = NUM_IDS / 64;

    logic page_ok;
    logic grp_ok;

    // Page selection from privilege, virtualization flag and guest index.
    generate
        if (MACHINE_FILE) begin : g_mach
            always_comb begin
                page    = '0;
                page_ok = (priv == PRIV_M) && !virt;
            end
        end else begin : g_sup
            always_comb begin
                page    = '0;
                page_ok = 1'b0;
                if (priv == PRIV_S) begin
                    if (!virt) begin
                        page_ok = 1'b1;
                    end else if ((guest != '0) &&
                                 ({{(32-GUEST_W){1'b0}}, guest} < 32'(NUM_PAGES))) begin
                        page_ok = 1'b1;
                        page    = guest[PAGE_W-1:0];
                    end
                end
            end
        end
    endgenerate

    // Register kind from the select code.
    always_comb begin
        kind = K_NONE;
        case (sel[7:6])
            2'b00:   kind = K_PEND;
            2'b01:   kind = K_EN;
            default: begin
                if (sel == SEL_DLV)      kind = K_DLV;
                else if (sel == SEL_THR) kind = K_THR;
                else if (sel == SEL_TOP) kind = K_TOP;
            end
        endcase
    end

    // Group word index and its range check for the current width.
    always_comb begin
        word   = wide ? {1'b0, sel[5:1]} : sel[5:0];
        grp_ok = wide ? (!sel[0] && ({26'd0, word} < 32'(WORDS_64)))
                      : ({26'd0, word} < 32'(WORDS_32));
    end

    // Overall legality.
    always_comb begin
        legal = page_ok && (kind != K_NONE) &&
                (((kind != K_PEND) && (kind != K_EN)) || grp_ok);
    end

endmodule

// File: rtl/ifile_bit_store.sv
// Module: ifile_bit_store
// Holds one state bit per identity for each page, as one flat vector per
// page. It reads a 32- or 64-bit group and applies a masked write to it in
// the same cycle. Identity 0 is never written and always reads zero.
// Assumes NUM_IDS is a power of two of at least 128.
module ifile_bit_store #(
    parameter int NUM_PAGES = 4,
    parameter int NUM_IDS   = 128,
    parameter int PAGE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] page,
    input  logic [5:0]        word,
    input  logic              wide,
    input  logic [63:0]       wdata,
    input  logic [63:0]       wmask,
    output logic [63:0]       rdata
);

    logic [NUM_IDS-1:0] bits_q [NUM_PAGES];
    logic [NUM_IDS-1:0] cur_vec;
    logic [NUM_IDS-1:0] shifted;
    logic [NUM_IDS-1:0] mask_ext;
    logic [NUM_IDS-1:0] data_ext;
    logic [63:0]        width_mask;
    logic [63:0]        keep_mask;
    int unsigned        base;

    // Group placement: bit offset of the group and the mask for its width.
    always_comb begin
        base       = {26'd0, word} * (wide ? 32'd64 : 32'd32);
        width_mask = wide ? {64{1'b1}} : {32'd0, {32{1'b1}}};
        keep_mask  = width_mask & ((word == 6'd0) ? ~64'd1 : {64{1'b1}});
    end

    // Read the old group value from the selected page.
    always_comb begin
        cur_vec = bits_q[page];
        shifted = cur_vec >> base;
        rdata   = shifted[63:0] & keep_mask;
    end

    // Place the write mask and data at the group position.
    always_comb begin
        mask_ext = NUM_IDS'(wmask & keep_mask) << base;
        data_ext = NUM_IDS'(wdata) << base;
    end

    // One state vector per page, updated only when that page is addressed.
    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bits_q[p] <= '0;
                end else if (wr_en && (page == PAGE_W'(p))) begin
                    bits_q[p] <= (bits_q[p] & ~mask_ext) | (data_ext & mask_ext);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ifile_page_regs.sv
// Module: ifile_page_regs
// Per-page delivery control bit and threshold value. Both take masked
// writes and return their old value, zero-extended to 64 bits.
module ifile_page_regs #(
    parameter int NUM_PAGES = 4,
    parameter int PAGE_W    = 2,
    parameter int THR_W     = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dlv,
    input  logic              wr_thr,
    input  logic [PAGE_W-1:0] page,
    input  logic [THR_W-1:0]  wdata,
    input  logic [THR_W-1:0]  wmask,
    output logic [63:0]       dlv_rd,
    output logic [63:0]       thr_rd
);

    logic             dlv_q [NUM_PAGES];
    logic [THR_W-1:0] thr_q [NUM_PAGES];

    // Old-value read for the selected page.
    always_comb begin
        dlv_rd = {63'd0, dlv_q[page]};
        thr_rd = 64'(thr_q[page]);
    end

    // Per-page storage with masked update.
    generate
        for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    dlv_q[p] <= 1'b0;
                    thr_q[p] <= '0;
                end else if (page == PAGE_W'(p)) begin
                    if (wr_dlv && wmask[0]) dlv_q[p] <= wdata[0];
                    if (wr_thr) thr_q[p] <= (thr_q[p] & ~wmask) | (wdata & wmask);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ifile_ireg_decoder.sv
// Module: ifile_ireg_decoder (top)
// Front end of an interrupt file. It decodes indirect register accesses,
// performs a masked read-modify-write on the page-selected register, and
// answers one cycle later with the old value or an error. A legal access
// also raises an update strobe for its page.
// Assumes NUM_IDS is a power of two of at least 128. The top-interrupt
// select is legal here, but its selection logic lives downstream.
module ifile_ireg_decoder
    import ifile_pkg::*;
#(
    parameter int NUM_PAGES    = 4,
    parameter int NUM_IDS      = 128,
    parameter int GUEST_W      = 6,
    parameter int THR_W        = 11,
    parameter bit MACHINE_FILE = 1'b0,
    localparam int PAGE_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [7:0]         req_sel,
    input  logic [1:0]         req_priv,
    input  logic               req_virt,
    input  logic [GUEST_W-1:0] req_guest,
    input  logic               req_wide,
    input  logic [63:0]        req_wdata,
    input  logic [63:0]        req_wmask,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [63:0]        rsp_rdata,
    output logic               upd_valid,
    output logic [PAGE_W-1:0]  upd_page
);

    logic              legal;
    ireg_kind_e        kind;
    logic [PAGE_W-1:0] page;
    logic [5:0]        word;
    logic              fire;
    logic [63:0]       pend_rd;
    logic [63:0]       en_rd;
    logic [63:0]       dlv_rd;
    logic [63:0]       thr_rd;
    logic [63:0]       rd_mux;

    ifile_access_decode #(
        .NUM_PAGES   (NUM_PAGES),
        .NUM_IDS     (NUM_IDS),
        .GUEST_W     (GUEST_W),
        .MACHINE_FILE(MACHINE_FILE),
        .PAGE_W      (PAGE_W)
    ) u_decode (
        .sel  (req_sel),
        .priv (req_priv),
        .virt (req_virt),
        .guest(req_guest),
        .wide (req_wide),
        .legal(legal),
        .kind (kind),
        .page (page),
        .word (word)
    );

    // Access fires only for a valid and legal request.
    always_comb fire = req_valid && legal;

    ifile_bit_store #(
        .NUM_PAGES(NUM_PAGES),
        .NUM_IDS  (NUM_IDS),
        .PAGE_W   (PAGE_W)
    ) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(fire && (kind == K_PEND)),
        .page (page),
        .word (word),
        .wide (req_wide),
        .wdata(req_wdata),
        .wmask(req_wmask),
        .rdata(pend_rd)
    );

    ifile_bit_store #(
        .NUM_PAGES(NUM_PAGES),
        .NUM_IDS  (NUM_IDS),
        .PAGE_W   (PAGE_W)
    ) u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(fire && (kind == K_EN)),
        .page (page),
        .word (word),
        .wide (req_wide),
        .wdata(req_wdata),
        .wmask(req_wmask),
        .rdata(en_rd)
    );

    ifile_page_regs #(
        .NUM_PAGES(NUM_PAGES),
        .PAGE_W   (PAGE_W),
        .THR_W    (THR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_dlv(fire && (kind == K_DLV)),
        .wr_thr(fire && (kind == K_THR)),
        .page  (page),
        .wdata (req_wdata[THR_W-1:0]),
        .wmask (req_wmask[THR_W-1:0]),
        .dlv_rd(dlv_rd),
        .thr_rd(thr_rd)
    );

    // Old-value select by register kind; the top register reads zero here.
    always_comb begin
        case (kind)
            K_PEND:  rd_mux = pend_rd;
            K_EN:    rd_mux = en_rd;
            K_DLV:   rd_mux = dlv_rd;
            K_THR:   rd_mux = thr_rd;
            default: rd_mux = 64'd0;
        endcase
    end

    // Registered response and update strobe, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= 64'd0;
            upd_valid <= 1'b0;
            upd_page  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !legal;
            rsp_rdata <= fire ? rd_mux : 64'd0;
            upd_valid <= fire;
            upd_page  <= fire ? page : '0;
        end
    end

endmodule

// File: rtl/ifile_ireg_checker.sv
// Module: ifile_ireg_checker
// Protocol and decode properties of ifile_ireg_decoder, attached by bind.
module ifile_ireg_checker #(
    parameter int NUM_PAGES    = 4,
    parameter bit MACHINE_FILE = 1'b0,
    parameter int PAGE_W       = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [7:0]        req_sel,
    input logic              req_wide,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              upd_valid,
    input logic [PAGE_W-1:0] upd_page
);

    // R1: request answered in the next cycle.
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1: no response without a request.
    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R10: errors return zero and raise no update.
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'd0) && !upd_valid);
    // R11: a legal response comes with the update strobe.
    p_success_upd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> upd_valid);
    // R2: the update page is always an existing page.
    p_upd_page_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (32'(upd_page) < 32'(NUM_PAGES)));
    // R3: a machine-level file only ever touches page 0.
    p_mach_page0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (MACHINE_FILE && upd_valid) |-> (upd_page == '0));
    // R4: undefined select codes are rejected.
    p_bad_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_sel > 8'h82)) |=> rsp_err);
    // R5: odd groups in 64-bit mode are rejected.
    p_odd_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_wide && !req_sel[7] && req_sel[0]) |=> rsp_err);
    // R9: identity 0 reads zero.
    p_id0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_sel == 8'h00) || (req_sel == 8'h40))) |=> !rsp_rdata[0]);
    // R8: delivery control has a single bit.
    p_dlv_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_sel == 8'h80)) |=> (rsp_rdata[63:1] == 63'd0));

endmodule

bind ifile_ireg_decoder ifile_ireg_checker #(
    .NUM_PAGES   (NUM_PAGES),
    .MACHINE_FILE(MACHINE_FILE),
    .PAGE_W      (PAGE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_sel  (req_sel),
    .req_wide (req_wide),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .rsp_rdata(rsp_rdata),
    .upd_valid(upd_valid),
    .upd_page (upd_page)
);

// File: tb/ifile_ireg_decoder_bench.sv
// Bench: sweeps of privilege, guest index, select code and width, plus
// pattern fills of every page. It runs against a supervisor-level instance
// with 4 pages and a machine-level instance with 1 page that receive the
// same requests.
module ifile_ireg_decoder_bench;

    localparam int NP  = 4;
    localparam int NI  = 128;
    localparam int GW  = 3;
    localparam int TW  = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_sel = '0;
    logic [1:0]  req_priv = '0;
    logic        req_virt = 1'b0;
    logic [GW-1:0] req_guest = '0;
    logic        req_wide = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_wmask = '0;

    logic        rsp_valid, rsp_err, upd_valid;
    logic [63:0] rsp_rdata;
    logic [1:0]  upd_page;
    logic        m_rsp_valid, m_rsp_err, m_upd_valid;
    logic [63:0] m_rsp_rdata;
    logic [0:0]  m_upd_page;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [NI-1:0] mp [NP];
    logic [NI-1:0] me [NP];
    logic          md [NP];
    logic [TW-1:0] mt [NP];

    always #5 clk = ~clk;

    ifile_ireg_decoder #(.NUM_PAGES(NP), .NUM_IDS(NI), .GUEST_W(GW), .THR_W(TW),
                         .MACHINE_FILE(1'b0)) u_ifile_ireg_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_priv(req_priv), .req_virt(req_virt), .req_guest(req_guest),
        .req_wide(req_wide), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .upd_valid(upd_valid), .upd_page(upd_page));

    ifile_ireg_decoder #(.NUM_PAGES(1), .NUM_IDS(NI), .GUEST_W(GW), .THR_W(TW),
                         .MACHINE_FILE(1'b1)) u_ifile_ireg_decoder_m (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_priv(req_priv), .req_virt(req_virt), .req_guest(req_guest),
        .req_wide(req_wide), .req_wdata(req_wdata), .req_wmask(req_wmask),
        .rsp_valid(m_rsp_valid), .rsp_err(m_rsp_err), .rsp_rdata(m_rsp_rdata),
        .upd_valid(m_upd_valid), .upd_page(m_upd_page));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Select legality per R4, R5 and R6, independent of the page rules.
    function automatic bit sel_ok(input logic [7:0] sel, input logic w);
        int n, wi;
        if (sel == 8'h80 || sel == 8'h81 || sel == 8'h82) return 1'b1;
        if (sel[7]) return 1'b0;
        n = int'(sel[5:0]);
        if (w && n[0]) return 1'b0;
        wi = w ? n / 2 : n;
        return (wi * (w ? 64 : 32)) < NI;
    endfunction

    task automatic acc(input logic [7:0] sel, input logic [1:0] pr, input logic v,
                       input logic [GW-1:0] g, input logic w, input logic [63:0] d,
                       input logic [63:0] m, input string tag);
        bit ok, m_ok;
        int pg, base, width;
        logic [63:0] exp;
        logic [NI-1:0] tmp;
        // Page rules per R2 (supervisor) and R3 (machine).
        pg = 0;
        ok = 1'b0;
        if (pr == 2'b01) begin
            if (!v) ok = 1'b1;
            else if (g != 0 && int'(g) < NP) begin ok = 1'b1; pg = int'(g); end
        end
        ok   = ok && sel_ok(sel, w);
        m_ok = (pr == 2'b11) && !v && sel_ok(sel, w);
        width = w ? 64 : 32;
        base  = (w ? int'(sel[5:1]) : int'(sel[5:0])) * width;
        exp = 64'd0;
        if (ok) begin
            if (!sel[7]) begin
                tmp = sel[6] ? me[pg] : mp[pg];
                tmp = tmp >> base;
                exp = w ? tmp[63:0] : {32'd0, tmp[31:0]};
                for (int i = 0; i < width; i++) begin
                    if ((base + i) != 0 && m[i]) begin
                        if (sel[6]) me[pg][base+i] = d[i];
                        else        mp[pg][base+i] = d[i];
                    end
                end
            end else if (sel == 8'h80) begin
                exp = {63'd0, md[pg]};
                if (m[0]) md[pg] = d[0];
            end else if (sel == 8'h81) begin
                exp = 64'(mt[pg]);
                mt[pg] = (mt[pg] & ~m[TW-1:0]) | (d[TW-1:0] & m[TW-1:0]);
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_priv = pr; req_virt = v;
        req_guest = g; req_wide = w; req_wdata = d; req_wmask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " R10 rsp_err"}, 64'(rsp_err), 64'(!ok));
        chk({tag, " R7 rdata"}, rsp_rdata, exp);
        chk({tag, " R11 upd_valid"}, 64'(upd_valid), 64'(ok));
        chk({tag, " R11 upd_page"}, 64'(upd_page), ok ? 64'(pg) : 64'd0);
        chk({tag, " R3 m_err"}, 64'(m_rsp_err), 64'(!m_ok));
        chk({tag, " R3 m_upd"}, 64'(m_upd_valid), 64'(m_ok));
    endtask

    function automatic logic [63:0] pat(input int p, input int wd, input int salt);
        return 64'h9E37_79B9_7F4A_7C15 * 64'(p * 16 + wd * 3 + salt + 1);
    endfunction

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) begin
            mp[p] = '0; me[p] = '0; md[p] = 1'b0; mt[p] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("reset R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("reset R11 upd_valid", 64'(upd_valid), 64'd0);
        chk("reset R10 rsp_err", 64'(rsp_err), 64'd0);
        rst_n = 1'b1;

        // R2 and R3: privilege, virtualization and guest sweep on delivery reads.
        for (int pr = 0; pr < 4; pr++)
            for (int v = 0; v < 2; v++)
                for (int g = 0; g < 8; g++)
                    acc(8'h80, 2'(pr), 1'(v), 3'(g), 1'b0, '0, '0, "R2 priv sweep");

        // R4, R5, R6: every select code in both widths, read only.
        for (int s = 0; s < 256; s++)
            for (int w = 0; w < 2; w++)
                acc(8'(s), 2'b01, 1'b0, 3'd0, 1'(w), '0, '0, "R4 sel sweep");

        // R7, R9, R13: fill every page's pending and enable groups.
        for (int p = 0; p < NP; p++)
            for (int wd = 0; wd < 4; wd++) begin
                acc(8'(wd), 2'b01, p != 0, 3'(p), 1'b0, pat(p, wd, 0), '1, "R7 pend fill");
                acc(8'h40 + 8'(wd), 2'b01, p != 0, 3'(p), 1'b0, pat(p, wd, 5), '1, "R9 en fill");
            end
        // R5, R13: 64-bit read-back with a partial mask.
        for (int p = 0; p < NP; p++)
            for (int n = 0; n < 4; n += 2) begin
                acc(8'(n), 2'b01, p != 0, 3'(p), 1'b1, pat(p, n, 9),
                    64'h00FF_00F0_0F0F_F00F, "R5 pend wide");
                acc(8'h40 + 8'(n), 2'b01, p != 0, 3'(p), 1'b1, pat(p, n, 11),
                    64'hF0F0_0000_FFFF_0001, "R13 en wide");
            end

        // R8: delivery and threshold write masks.
        for (int p = 0; p < NP; p++) begin
            acc(8'h80, 2'b01, p != 0, 3'(p), 1'b0, '1, '1, "R8 dlv set");
            acc(8'h81, 2'b01, p != 0, 3'(p), 1'b0, '1, '1, "R8 thr set");
            acc(8'h81, 2'b01, p != 0, 3'(p), 1'b0, 64'd0, 64'h5, "R8 thr part");
            acc(8'h80, 2'b01, p != 0, 3'(p), 1'b0, 64'd0, 64'h2, "R8 dlv mask");
        end

        // R12: top-interrupt writes change nothing.
        acc(8'h82, 2'b01, 1'b0, 3'd0, 1'b1, '1, '1, "R12 top write");
        acc(8'h82, 2'b01, 1'b1, 3'd2, 1'b0, '1, '1, "R12 top write g2");

        // R10: illegal writes change nothing (guest 0, bad guest, odd wide, bad priv).
        acc(8'h00, 2'b01, 1'b1, 3'd0, 1'b0, 64'd0, '1, "R10 guest0");
        acc(8'h41, 2'b01, 1'b1, 3'd5, 1'b0, 64'd0, '1, "R10 guest5");
        acc(8'h01, 2'b01, 1'b0, 3'd0, 1'b1, 64'd0, '1, "R10 odd wide");
        acc(8'h80, 2'b11, 1'b0, 3'd0, 1'b0, 64'd0, '1, "R10 mach priv");

        // Final read-back of everything (R7, R9, R12, R13, R10).
        for (int p = 0; p < NP; p++) begin
            for (int wd = 0; wd < 4; wd++) begin
                acc(8'(wd), 2'b01, p != 0, 3'(p), 1'b0, '0, '0, "R13 final pend");
                acc(8'h40 + 8'(wd), 2'b01, p != 0, 3'(p), 1'b0, '0, '0, "R13 final en");
            end
            acc(8'h80, 2'b01, p != 0, 3'(p), 1'b0, '0, '0, "R8 final dlv");
            acc(8'h81, 2'b01, p != 0, 3'(p), 1'b0, '0, '0, "R8 final thr");
        end

        // R1, R11: pulses last exactly one cycle.
        @(negedge clk);
        chk("R1 single pulse", 64'(rsp_valid), 64'd0);
        chk("R11 single pulse", 64'(upd_valid), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule